// File: doc/BRIEF.md
# Video Output Byte Formatter

This block turns processed pixel data into an 8-bit byte stream for a downstream serializer. It runs at the byte rate. The source holds each input word on `in_pix` for every output byte that the word produces. In the two-byte-per-pixel formats a word is one pixel and is held for two cycles. In the 4:2:2 luma/chroma format a word is a pixel pair and is held for four cycles. The byte index restarts at zero on every line, so each line begins at the first byte of a group.

Four output formats are available. The first is 4:2:2 luma/chroma with four byte orderings. The second is RGB 5-6-5 packing, which can exchange its bytes and its red/blue fields. The third splits a raw Bayer sample into a high byte and a low byte. The fourth is a progressive embedded-timing stream. In that format the line and frame flags stay low, and start/end reference codes and a blanking fill carry all the timing. The format and the two swap bits take effect only at the rising edge of frame-valid.

Top module: `vid_byte_fmt`

## Requirements
- R1: After reset `out_byte`, `out_lv` and `out_fv` are all 0. The configuration starts as luma/chroma format with both swaps off.
- R2: In formats 0, 1 and 2, `out_lv` and `out_fv` equal `in_lv` and `in_fv` one cycle later. `out_byte` carries the formatted byte one cycle after its input, and is 0 whenever `out_lv` is low.
- R3: Format 0 (`cfg_mode`=0) reads `in_pix` as Cb[31:24], Y0[23:16], Cr[15:8], Y1[7:0] and sends four bytes per word. The order depends on the swap bits. With no swap it is Cb,Y0,Cr,Y1. `cfg_swap_chroma` alone gives Cr,Y0,Cb,Y1. `cfg_swap_order` alone gives Y0,Cb,Y1,Cr. Both together give Y0,Cr,Y1,Cb.
- R4: Format 1 reads R[23:16], G[15:8], B[7:0] and sends two bytes per pixel. The first byte is {R[7:3],G[7:5]} and the second is {G[4:2],B[7:3]}. `cfg_swap_order` exchanges the two bytes. `cfg_swap_chroma` exchanges the R and B fields.
- R5: Format 2 reads a RAW_W-bit sample (10 by default) from the low bits of `in_pix` and sends two bytes: D[9:2], then six zero bits followed by D[1:0]. Both swap bits and the unused upper bits of `in_pix` have no effect.
- R6: Format 3 sends 0xFF,0x00,0x00,XY in the four cycles that follow each `in_lv` rise. Each active byte then appears five cycles after its input, and 0xFF,0x00,0x00,XY follows the line. XY = {1,F,V,H,V^H,F^H,F^V,F^V^H}, where F=0, V=!in_fv and H is 0 at the start of a line and 1 at its end. This gives 0x80/0x9D on active lines and 0xAB/0xB6 on blank lines.
- R7: In format 3 every byte that is neither a code nor active picture alternates 0x80,0x10, starting with 0x80 after each code. Active positions of lines with `in_fv` low are filled in the same way.
- R8: In format 3 `out_lv` and `out_fv` stay low.
- R9: `cfg_mode` and both swap bits are captured only at a rising edge of `in_fv`. Changes at any other time leave the current frame's format unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_fv | input | 1 | Input frame valid |
| in_lv | input | 1 | Input line valid, high for each output byte slot of a line |
| in_pix | input | 32 | Pixel word, layout set by the format |
| cfg_mode | input | 2 | 0 luma/chroma, 1 RGB 5-6-5, 2 raw split, 3 embedded timing |
| cfg_swap_chroma | input | 1 | Exchange Cb/Cr or R/B |
| cfg_swap_order | input | 1 | Exchange luma/chroma slots or the two RGB bytes |
| out_fv | output | 1 | Output frame valid |
| out_lv | output | 1 | Output line valid |
| out_byte | output | 8 | Output byte |

## Verification
The bench uses the default parameters: RAW_W=10, the embedded-timing inserter built in, and fill values 0x80/0x10. These make the exact 8+2 raw split reachable, along with the full reference-code path with its five-cycle data delay and both the active-line and blank-line status words. Every swap combination is driven in the luma/chroma and RGB formats. A configuration change in mid-frame is applied and its effect is checked to be deferred to the next frame.

// File: rtl/vbf_pkg.sv
`timescale 1ns/1ps
package vbf_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 4 * BYTE_W;

   typedef enum logic [1:0] {
      FMT_YCC = 2'd0,
      FMT_RGB = 2'd1,
      FMT_RAW = 2'd2,
      FMT_EMB = 2'd3
   } fmt_e;

   typedef struct packed {
      fmt_e mode;
      logic sw_chroma;
      logic sw_order;
   } cfg_t;

   // status byte of a timing reference with its protection bits
   function automatic logic [BYTE_W-1:0] ref_status(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction
endpackage

// File: rtl/vbf_byte_sel.sv
`timescale 1ns/1ps
module vbf_byte_sel
   import vbf_pkg::*;
#(
   parameter int RAW_W = 10
) (
   input  cfg_t              cfg,
   input  logic [1:0]        idx,
   input  logic [WORD_W-1:0] pix,
   output logic [BYTE_W-1:0] byte_o
);
   localparam int LO_W = RAW_W - BYTE_W;

   logic [BYTE_W-1:0] c_b, c_r, l_0, l_1;
   logic [BYTE_W-1:0] red, grn, blu;
   logic [4:0]        f_hi, f_lo;
   logic [RAW_W-1:0]  raw;
   logic              luma_slot, rgb_second;

   assign c_b = pix[4*BYTE_W-1:3*BYTE_W];
   assign l_0 = pix[3*BYTE_W-1:2*BYTE_W];
   assign c_r = pix[2*BYTE_W-1:BYTE_W];
   assign l_1 = pix[BYTE_W-1:0];
   assign red = pix[3*BYTE_W-1:2*BYTE_W];
   assign grn = pix[2*BYTE_W-1:BYTE_W];
   assign blu = pix[BYTE_W-1:0];
   assign raw = pix[RAW_W-1:0];

   always_comb begin
      luma_slot  = idx[0] ^ cfg.sw_order;
      rgb_second = idx[0] ^ cfg.sw_order;
      f_hi       = cfg.sw_chroma ? blu[7:3] : red[7:3];
      f_lo       = cfg.sw_chroma ? red[7:3] : blu[7:3];
      unique case (cfg.mode)
         FMT_RGB: byte_o = rgb_second ? {grn[4:2], f_lo} : {f_hi, grn[7:5]};
         FMT_RAW: byte_o = idx[0] ? BYTE_W'(raw[LO_W-1:0]) : raw[RAW_W-1:LO_W];
         default: begin
            if (luma_slot) byte_o = idx[1] ? l_1 : l_0;
            else           byte_o = (idx[1] ^ cfg.sw_chroma) ? c_r : c_b;
         end
      endcase
   end
endmodule

// File: rtl/vbf_ref_ins.sv
`timescale 1ns/1ps
module vbf_ref_ins
   import vbf_pkg::*;
#(
   parameter logic [BYTE_W-1:0] FILL_C = 8'h80,
   parameter logic [BYTE_W-1:0] FILL_Y = 8'h10,
   parameter int                LEAD   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_lv,
   input  logic              s_fv,
   input  logic [BYTE_W-1:0] s_byte,
   output logic [BYTE_W-1:0] o_byte
);
   localparam int LV_D = 2 * LEAD;
   localparam int FV_D = 2 * LEAD - 1;

   logic [LV_D:1]      lv_sr;
   logic [FV_D:1]      fv_sr;
   logic [LV_D:0]      lv_v;
   logic [FV_D:0]      fv_v;
   logic [BYTE_W-1:0]  dat_sr [1:LEAD];
   logic               tog, code_hit, code_eav, vb, fill_sel, code_last;
   logic [1:0]         code_k;
   logic [BYTE_W-1:0]  nxt;

   assign lv_v = {lv_sr, s_lv};
   assign fv_v = {fv_sr, s_fv};

   always_comb begin
      code_hit = 1'b0;
      code_eav = 1'b0;
      code_k   = 2'd0;
      for (int k = 0; k < LEAD; k++) begin
         if (lv_v[k] && !lv_v[k+1]) begin
            code_hit = 1'b1; code_eav = 1'b0; code_k = 2'(k);
         end
         if (!lv_v[k+LEAD] && lv_v[k+LEAD+1]) begin
            code_hit = 1'b1; code_eav = 1'b1; code_k = 2'(k);
         end
      end
      vb        = code_eav ? !fv_v[FV_D] : !fv_v[LEAD-1];
      code_last = code_hit && (code_k == 2'(LEAD-1));
      fill_sel  = 1'b0;
      if (code_hit) begin
         unique case (code_k)
            2'd0:    nxt = 8'hFF;
            2'd3:    nxt = ref_status(1'b0, vb, code_eav);
            default: nxt = 8'h00;
         endcase
      end else if (lv_v[LEAD] && fv_v[LEAD]) begin
         nxt = dat_sr[LEAD];
      end else begin
         fill_sel = 1'b1;
         nxt      = tog ? FILL_Y : FILL_C;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_sr  <= '0;
         fv_sr  <= '0;
         tog    <= 1'b0;
         o_byte <= '0;
         for (int i = 1; i <= LEAD; i++) dat_sr[i] <= '0;
      end else begin
         lv_sr     <= lv_v[LV_D-1:0];
         fv_sr     <= fv_v[FV_D-1:0];
         dat_sr[1] <= s_byte;
         for (int i = 2; i <= LEAD; i++) dat_sr[i] <= dat_sr[i-1];
         o_byte    <= nxt;
         if (code_last)     tog <= 1'b0;
         else if (fill_sel) tog <= ~tog;
      end
   end
endmodule

// File: rtl/vid_byte_fmt.sv
`timescale 1ns/1ps
module vid_byte_fmt
   import vbf_pkg::*;
#(
   parameter int                RAW_W     = 10,
   parameter bit                HAS_EMB   = 1'b1,
   parameter logic [BYTE_W-1:0] FILL_C    = 8'h80,
   parameter logic [BYTE_W-1:0] FILL_Y    = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_fv,
   input  logic              in_lv,
   input  logic [31:0]       in_pix,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_swap_chroma,
   input  logic              cfg_swap_order,
   output logic              out_fv,
   output logic              out_lv,
   output logic [7:0]        out_byte
);
   if (RAW_W < BYTE_W + 1 || RAW_W > 2 * BYTE_W) begin : g_bad_raw
      $error("vid_byte_fmt: RAW_W must lie in 9..16");
   end
   if (FILL_C == 8'hFF || FILL_Y == 8'hFF) begin : g_bad_fill
      $error("vid_byte_fmt: fill values may not mimic a reference preamble");
   end

   cfg_t              cfg_q;
   logic              fv_q, p_lv, p_fv, emb_sel;
   logic [1:0]        idx;
   logic [BYTE_W-1:0] fmt_byte, p_byte, t_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '{mode: FMT_YCC, sw_chroma: 1'b0, sw_order: 1'b0};
         fv_q   <= 1'b0;
         idx    <= '0;
         p_lv   <= 1'b0;
         p_fv   <= 1'b0;
         p_byte <= '0;
      end else begin
         fv_q <= in_fv;
         if (in_fv && !fv_q)
            cfg_q <= '{mode: fmt_e'(cfg_mode), sw_chroma: cfg_swap_chroma, sw_order: cfg_swap_order};
         idx    <= in_lv ? idx + 2'd1 : 2'd0;
         p_lv   <= in_lv;
         p_fv   <= in_fv;
         p_byte <= in_lv ? fmt_byte : '0;
      end
   end

   vbf_byte_sel #(.RAW_W(RAW_W)) u_sel (
      .cfg    (cfg_q),
      .idx    (idx),
      .pix    (in_pix),
      .byte_o (fmt_byte)
   );

   if (HAS_EMB) begin : g_emb
      vbf_ref_ins #(.FILL_C(FILL_C), .FILL_Y(FILL_Y), .LEAD(4)) u_ins (
         .clk    (clk),
         .rst_n  (rst_n),
         .s_lv   (in_lv),
         .s_fv   (in_fv),
         .s_byte (fmt_byte),
         .o_byte (t_byte)
      );
      assign emb_sel = (cfg_q.mode == FMT_EMB);
   end else begin : g_no_emb
      assign t_byte  = '0;
      assign emb_sel = 1'b0;
   end

   assign out_lv   = emb_sel ? 1'b0 : p_lv;
   assign out_fv   = emb_sel ? 1'b0 : p_fv;
   assign out_byte = emb_sel ? t_byte : p_byte;
endmodule

// File: rtl/vid_byte_fmt_chk.sv
`timescale 1ns/1ps
module vid_byte_fmt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_fv,
   input logic       in_lv,
   input logic       out_fv,
   input logic       out_lv,
   input logic [7:0] out_byte,
   input logic [3:0] cfg_bits,
   input logic       emb_on
);
   logic odd_b;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) odd_b <= 1'b0;
      else        odd_b <= out_lv ? ~odd_b : 1'b0;
   end

   // R2: flags follow the inputs by one cycle
   a_r2_flag_delay: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !emb_on) |-> (out_lv == $past(in_lv) && out_fv == $past(in_fv)));

   // R2: byte is zero outside a line
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!emb_on && !out_lv) |-> (out_byte == 8'h00));

   // R5: second byte of a raw sample has zero upper bits
   a_r5_low_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (!emb_on && cfg_bits[3:2] == 2'd2 && out_lv && odd_b) |-> (out_byte[7:2] == 6'd0));

   // R6: a preamble start is followed by a zero byte
   a_r6_preamble: assert property (@(posedge clk) disable iff (!rst_n)
      (emb_on && out_byte == 8'hFF) |=> (out_byte == 8'h00));

   // R8: no flags in the embedded-timing format
   a_r8_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
      emb_on |-> (!out_lv && !out_fv));

   // R9: configuration moves only after a frame start
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$rose(in_fv)) |=> $stable(cfg_bits));
endmodule

bind vid_byte_fmt vid_byte_fmt_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_fv    (in_fv),
   .in_lv    (in_lv),
   .out_fv   (out_fv),
   .out_lv   (out_lv),
   .out_byte (out_byte),
   .cfg_bits (cfg_q),
   .emb_on   (emb_sel)
);

// File: tb/sim_vid_byte_fmt.sv
`timescale 1ns/1ps
module sim_vid_byte_fmt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_fv = 1'b0, in_lv = 1'b0;
   logic [31:0] in_pix = '0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        cfg_swap_chroma = 1'b0, cfg_swap_order = 1'b0;
   logic        out_fv, out_lv;
   logic [7:0]  out_byte;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   vid_byte_fmt u0 (.*);

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] e_ycc(input logic [31:0] w, input int k, input bit sc, input bit so);
      logic [7:0] cb, y0, cr, y1;
      logic [31:0] s;
      cb = w[31:24]; y0 = w[23:16]; cr = w[15:8]; y1 = w[7:0];
      case ({so, sc})
         2'b00: s = {cb, y0, cr, y1};
         2'b01: s = {cr, y0, cb, y1};
         2'b10: s = {y0, cb, y1, cr};
         default: s = {y0, cr, y1, cb};
      endcase
      return s[31-8*k -: 8];
   endfunction

   function automatic logic [7:0] e_rgb(input logic [31:0] w, input int k, input bit sc, input bit so);
      logic [7:0] r, g, b, f0, f1;
      r = w[23:16]; g = w[15:8]; b = w[7:0];
      f0 = sc ? {b[7:3], g[7:5]} : {r[7:3], g[7:5]};
      f1 = sc ? {g[4:2], r[7:3]} : {g[4:2], b[7:3]};
      if (so) return (k == 0) ? f1 : f0;
      return (k == 0) ? f0 : f1;
   endfunction

   function automatic logic [7:0] e_raw(input logic [31:0] w, input int k);
      return (k == 0) ? w[9:2] : {6'b0, w[1:0]};
   endfunction

   task automatic start_frame(input int m, input bit sc, input bit so);
      in_fv = 1'b0; tick(); tick();
      cfg_mode = 2'(m); cfg_swap_chroma = sc; cfg_swap_order = so;
      in_fv = 1'b1; tick();
      chk((m == 3) ? "R8 fv low" : "R2 fv follows", {31'b0, out_fv}, (m == 3) ? 0 : 1);
      tick();
   endtask

   task automatic end_frame();
      in_fv = 1'b0; tick();
      chk("R2 fv drop", {31'b0, out_fv}, 0);
   endtask

   task automatic run_line(input int m, input bit sc, input bit so,
                           input logic [31:0] w0, input logic [31:0] w1, input string tag);
      int bpw;
      logic [7:0] e;
      bpw = (m == 0) ? 4 : 2;
      for (int g = 0; g < 2; g++) begin
         for (int b = 0; b < bpw; b++) begin
            in_pix = (g == 0) ? w0 : w1;
            in_lv = 1'b1; tick();
            if (m == 0)      e = e_ycc(in_pix, b, sc, so);
            else if (m == 1) e = e_rgb(in_pix, b, sc, so);
            else             e = e_raw(in_pix, b);
            chk(tag, {24'b0, out_byte}, {24'b0, e});
            chk("R2 lv high", {31'b0, out_lv}, 1);
         end
      end
      in_lv = 1'b0; tick();
      chk("R2 lv low", {31'b0, out_lv}, 0);
      chk("R2 idle byte", {24'b0, out_byte}, 0);
      tick();
   endtask

   task automatic t_reset();
      rst_n = 1'b0; tick(); tick();
      rst_n = 1'b1; #0;
      chk("R1 byte", {24'b0, out_byte}, 0);
      chk("R1 lv", {31'b0, out_lv}, 0);
      chk("R1 fv", {31'b0, out_fv}, 0);
      tick();
      chk("R1 idle after reset", {24'b0, out_byte}, 0);
   endtask

   task automatic t_ycc();
      for (int c = 0; c < 4; c++) begin
         start_frame(0, c[0], c[1]);
         run_line(0, c[0], c[1], 32'h11223344, 32'hA5B6C7D8, "R3 ycc order");
         run_line(0, c[0], c[1], 32'h0F1E2D3C, 32'h4B5A6978, "R3 ycc line restart");
         end_frame();
      end
   endtask

   task automatic t_rgb();
      for (int c = 0; c < 4; c++) begin
         start_frame(1, c[0], c[1]);
         run_line(1, c[0], c[1], 32'h00F81C07, 32'h0013E4AA, "R4 rgb565");
         end_frame();
      end
   endtask

   task automatic t_raw();
      start_frame(2, 1'b1, 1'b1);
      run_line(2, 1'b1, 1'b1, 32'hFFFFF3A7, 32'h0000015A, "R5 raw split swaps ignored");
      end_frame();
   endtask

   task automatic t_cfg_hold();
      start_frame(0, 1'b0, 1'b0);
      run_line(0, 1'b0, 1'b0, 32'h10203040, 32'h50607080, "R9 before change");
      cfg_mode = 2'd1; cfg_swap_chroma = 1'b1; cfg_swap_order = 1'b1;
      tick();
      run_line(0, 1'b0, 1'b0, 32'h90A0B0C0, 32'hD0E0F011, "R9 mid-frame change ignored");
      end_frame();
      start_frame(1, 1'b1, 1'b1);
      run_line(1, 1'b1, 1'b1, 32'h00F81C07, 32'h0013E4AA, "R9 new frame applies");
      end_frame();
   endtask

   task automatic emb_line(input bit vline);
      logic [31:0] w0, w1;
      logic [7:0] e;
      int k;
      w0 = 32'h40516273; w1 = 32'h8495A6B7;
      for (int n = 0; n < 30; n++) begin
         in_lv  = (n < 8);
         in_pix = (n < 4) ? w0 : w1;
         tick();
         if (n == 0 || n == 12)      e = 8'hFF;
         else if (n == 3)            e = vline ? 8'hAB : 8'h80;
         else if (n == 15)           e = vline ? 8'hB6 : 8'h9D;
         else if ((n > 0 && n < 3) || (n > 12 && n < 15)) e = 8'h00;
         else if (n >= 4 && n < 12) begin
            k = n - 4;
            if (vline) e = (k % 2 == 0) ? 8'h80 : 8'h10;
            else       e = e_ycc((k < 4) ? w0 : w1, k % 4, 1'b0, 1'b0);
         end else e = (n % 2 == 0) ? 8'h80 : 8'h10;
         if (n < 4 || (n >= 12 && n < 16))
            chk(vline ? "R6 blank-line code" : "R6 active-line code", {24'b0, out_byte}, {24'b0, e});
         else if (n >= 4 && n < 12 && !vline)
            chk("R6 delayed data", {24'b0, out_byte}, {24'b0, e});
         else
            chk("R7 fill", {24'b0, out_byte}, {24'b0, e});
         chk("R8 flags low", {30'b0, out_lv, out_fv}, 0);
      end
   endtask

   task automatic t_emb();
      start_frame(3, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) tick();
      emb_line(1'b0);
      emb_line(1'b0);
      in_fv = 1'b0;
      emb_line(1'b1);
   endtask

   initial begin
      t_reset();
      t_ycc();
      t_rgb();
      t_raw();
      t_cfg_hold();
      t_emb();
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule